// File: doc/BRIEF.md
# Three-Mode Power State Controller

This block governs one power-manageable unit that can be in one of three steady modes: a full-speed run mode, a standby mode where processing is halted but interrupt monitoring stays alive, and a sleep mode with the lowest power and the least functionality. It watches a workload idle flag and a wake/interrupt input. An idle-timeout policy with two levels decides when to step down, and a wake request brings the unit back up. Every mode change is modelled as a transition of its own fixed length in clock cycles. During that time the unit cannot be used.

The sleep entry threshold is never allowed to fall below the sum of the sleep entry and sleep exit latencies. This break-even rule keeps the policy from choosing a deep mode whose overhead it cannot recover. A greedy test mode bypasses the rule and starts a sleep shutdown on the first idle cycle. A saturating accumulator adds, every cycle, a weight that stands for the power drawn in the present mode. It charges the run weight during any transition. The accumulator can be cleared synchronously.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, mode_o is 0 (run), ready_o is 1 and energy_o is 0.
- R2: In run, after STBY_IDLE consecutive cycles with idle_i high (counted from the cycle where the count reaches STBY_IDLE), a shutdown toward standby begins on the next cycle. Any cycle with idle_i low restarts the count from zero.
- R3: Every transition shows mode_o = 3 for exactly its latency in cycles: SHUT_STBY_LAT (run to standby), SHUT_SLP_LAT (run or standby to sleep), STBY_EXIT_LAT (standby to run), SLEEP_EXIT_LAT (sleep to run). The steady codes are 0 = run, 1 = standby and 2 = sleep.
- R4: In standby, a shutdown toward sleep begins after SLEEP_THR consecutive idle cycles, where SLEEP_THR is the larger of SLEEP_IDLE and SHUT_SLP_LAT + SLEEP_EXIT_LAT. A busy cycle in standby restarts the count and does not wake the unit.
- R5: A wake_i pulse in standby starts the standby exit transition on the next cycle, and run follows after STBY_EXIT_LAT cycles.
- R6: A wake_i pulse in sleep starts the sleep exit transition, and run follows after SLEEP_EXIT_LAT cycles.
- R7: A wake_i pulse during a shutdown transition is held. The low-power mode is shown for one cycle and the matching exit transition then begins with no further wake_i.
- R8: wake_i has no effect in run or during an exit transition.
- R9: With greedy_i high, the first idle cycle in run or standby starts a shutdown toward sleep, whatever the idle count.
- R10: Unless cleared, energy_o grows each cycle by W_RUN in run or in any transition, by W_STBY in standby and by W_SLP in sleep.
- R11: energy_o saturates at all ones and stays there until cleared.
- R12: clear_i high sets energy_o to 0 on the next cycle, with no weight added for that cycle.
- R13: ready_o is high exactly when mode_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_i | input | 1 | Workload idle in this cycle |
| wake_i | input | 1 | Wake request or interrupt |
| greedy_i | input | 1 | Test mode: sleep on first idle cycle |
| clear_i | input | 1 | Synchronous clear of the energy total |
| mode_o | output | 2 | 0 run, 1 standby, 2 sleep, 3 transition |
| ready_o | output | 1 | Unit usable (run mode) |
| energy_o | output | ACC_W | Saturating weighted energy total |

## Verification
Idle runs broken by a single busy cycle one short of the threshold show whether the idle count restarts or only pauses. A full sleep-threshold run in standby separates the break-even threshold from the plain sleep timeout. Wake pulses placed in run, in standby, in sleep, inside a shutdown and inside an exit transition test each rule: a wake is ignored, acted on at once, or held. Clear pulses, together with a second instance that has a narrow accumulator, test the per-mode weights, the charge during transitions and saturation.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PS_RUN, PS_SHUT_STBY, PS_STBY, PS_SHUT_SLP, PS_SLEEP, PS_WAKE_STBY, PS_WAKE_SLP
  } pstate_e;

  localparam logic [1:0] MODE_RUN  = 2'd0;
  localparam logic [1:0] MODE_STBY = 2'd1;
  localparam logic [1:0] MODE_SLP  = 2'd2;
  localparam logic [1:0] MODE_TRAN = 2'd3;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [1:0] mode_of(input pstate_e s);
    case (s)
      PS_RUN:   return MODE_RUN;
      PS_STBY:  return MODE_STBY;
      PS_SLEEP: return MODE_SLP;
      default:  return MODE_TRAN;
    endcase
  endfunction

  function automatic logic is_shutdown(input pstate_e s);
    return (s == PS_SHUT_STBY) || (s == PS_SHUT_SLP);
  endfunction

endpackage

// File: rtl/pmc_idle_timer.sv
module pmc_idle_timer #(
  parameter int CNT_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         idle_i,
  output logic [CNT_W:0] streak_o
);
  logic [CNT_W-1:0] cnt_q;

  // streak including the present cycle
  assign streak_o = (en_i && idle_i) ? ({1'b0, cnt_q} + 1'b1) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || !idle_i)   cnt_q <= '0;
    else if (cnt_q != '1)        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmc_lat_timer.sv
module pmc_lat_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pmc_energy_acc.sv
module pmc_energy_acc #(
  parameter int ACC_W = 24,
  parameter int WGT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [WGT_W-1:0] weight_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W:0] sum;

  assign sum = {1'b0, acc_o} + {{(ACC_W + 1 - WGT_W){1'b0}}, weight_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          acc_o <= '0;
    else if (clear_i)     acc_o <= '0;
    else if (sum[ACC_W])  acc_o <= '1;
    else                  acc_o <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int STBY_IDLE      = 8,
  parameter int SLEEP_IDLE     = 64,
  parameter int SHUT_STBY_LAT  = 3,
  parameter int SHUT_SLP_LAT   = 6,
  parameter int STBY_EXIT_LAT  = 1,
  parameter int SLEEP_EXIT_LAT = 16000,
  parameter int W_RUN          = 16,
  parameter int W_STBY         = 4,
  parameter int W_SLP          = 1,
  parameter int ACC_W          = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             wake_i,
  input  logic             greedy_i,
  input  logic             clear_i,
  output logic [1:0]       mode_o,
  output logic             ready_o,
  output logic [ACC_W-1:0] energy_o
);
  // break-even: sleep only after idling longer than entry plus exit overhead
  localparam int SLEEP_THR = umax(SLEEP_IDLE, SHUT_SLP_LAT + SLEEP_EXIT_LAT);
  localparam int IDLE_W    = $clog2(SLEEP_THR + 1);
  localparam int LAT_MAX   = umax(umax(SHUT_STBY_LAT, SHUT_SLP_LAT),
                                  umax(STBY_EXIT_LAT, SLEEP_EXIT_LAT));
  localparam int LAT_W     = $clog2(LAT_MAX + 1);
  localparam int WGT_W     = $clog2(umax(W_RUN, umax(W_STBY, W_SLP)) + 1);

  localparam logic [IDLE_W:0]  STBY_N = (IDLE_W + 1)'(STBY_IDLE);
  localparam logic [IDLE_W:0]  SLP_N  = (IDLE_W + 1)'(SLEEP_THR);

  pstate_e           state_q, state_d;
  logic              pend_q, pend_d;
  logic [IDLE_W:0]   streak;
  logic              lat_done, lat_load;
  logic [LAT_W-1:0]  lat_val;
  logic [WGT_W-1:0]  weight;

  // named events for the checker
  logic shutting, wake_start, stby_due, sleep_due;

  function automatic logic [LAT_W-1:0] entry_lat(input pstate_e s);
    case (s)
      PS_SHUT_STBY: return LAT_W'(SHUT_STBY_LAT - 1);
      PS_SHUT_SLP:  return LAT_W'(SHUT_SLP_LAT - 1);
      PS_WAKE_STBY: return LAT_W'(STBY_EXIT_LAT - 1);
      default:      return LAT_W'(SLEEP_EXIT_LAT - 1);
    endcase
  endfunction

  function automatic logic [WGT_W-1:0] weight_of(input logic [1:0] m);
    case (m)
      MODE_STBY: return WGT_W'(W_STBY);
      MODE_SLP:  return WGT_W'(W_SLP);
      default:   return WGT_W'(W_RUN);
    endcase
  endfunction

  pmc_idle_timer #(.CNT_W(IDLE_W)) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    ((state_q == PS_RUN) || (state_q == PS_STBY)),
    .idle_i  (idle_i),
    .streak_o(streak)
  );

  pmc_lat_timer #(.W(LAT_W)) u_lat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(lat_load),
    .val_i (lat_val),
    .done_o(lat_done)
  );

  assign shutting   = is_shutdown(state_q);
  assign stby_due   = streak >= STBY_N;
  assign sleep_due  = (greedy_i && idle_i) || (streak >= SLP_N);
  assign wake_start = (state_q == PS_STBY || state_q == PS_SLEEP) && (wake_i || pend_q);

  always_comb begin
    state_d = state_q;
    case (state_q)
      PS_RUN: begin
        if (greedy_i && idle_i) state_d = PS_SHUT_SLP;
        else if (stby_due)      state_d = PS_SHUT_STBY;
      end
      PS_SHUT_STBY: if (lat_done) state_d = PS_STBY;
      PS_STBY: begin
        if (wake_start)     state_d = PS_WAKE_STBY;
        else if (sleep_due) state_d = PS_SHUT_SLP;
      end
      PS_SHUT_SLP: if (lat_done) state_d = PS_SLEEP;
      PS_SLEEP:    if (wake_start) state_d = PS_WAKE_SLP;
      PS_WAKE_STBY, PS_WAKE_SLP: if (lat_done) state_d = PS_RUN;
      default: state_d = PS_RUN;
    endcase
  end

  assign lat_load = (state_d != state_q) && (mode_of(state_d) == MODE_TRAN);
  assign lat_val  = entry_lat(state_d);

  always_comb begin
    pend_d = pend_q;
    if (wake_start)             pend_d = 1'b0;
    else if (shutting && wake_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_RUN;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign weight = weight_of(mode_of(state_q));

  pmc_energy_acc #(.ACC_W(ACC_W), .WGT_W(WGT_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .weight_i(weight),
    .acc_o   (energy_o)
  );

  assign mode_o  = mode_of(state_q);
  assign ready_o = (state_q == PS_RUN);

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int ACC_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             idle_i,
  input logic             wake_i,
  input logic             clear_i,
  input logic [1:0]       mode_o,
  input logic             ready_o,
  input logic [ACC_W-1:0] energy_o,
  input logic             shutting,
  input logic             pend_q
);
  localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

  a_r13_ready_is_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == (mode_o == 2'd0));

  a_r3_via_transition: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd3 && $past(mode_o) != 2'd3) |-> mode_o == $past(mode_o));

  a_r8_busy_run_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && !idle_i) |=> mode_o != 2'd1 && mode_o != 2'd2);

  a_r7_wake_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutting && wake_i) |=> pend_q);

  a_r12_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> energy_o == '0);

  a_r10_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && energy_o != FULL) |=> energy_o > $past(energy_o));

  a_r11_sat_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && energy_o == FULL) |=> energy_o == FULL);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .idle_i  (idle_i),
  .wake_i  (wake_i),
  .clear_i (clear_i),
  .mode_o  (mode_o),
  .ready_o (ready_o),
  .energy_o(energy_o),
  .shutting(shutting),
  .pend_q  (pend_q)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_STBY  = 8;
  localparam int T_SLEEP = 16006;   // larger of 64 and 6 + 16000
  localparam int L_SS    = 3;
  localparam int L_SL    = 6;
  localparam int L_XS    = 1;
  localparam int L_XL    = 16000;
  localparam longint MAX_MAIN = (64'd1 << 24) - 1;
  localparam longint MAX_SAT  = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle = 1'b0, wake = 1'b0, greedy = 1'b0, clr = 1'b0;
  logic [1:0] mode, mode_s;
  logic ready, ready_s;
  logic [23:0] energy;
  logic [7:0] energy_s;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .idle_i(idle), .wake_i(wake), .greedy_i(greedy),
    .clear_i(clr), .mode_o(mode), .ready_o(ready), .energy_o(energy)
  );

  pwr_mode_ctrl #(.ACC_W(8)) u_sat (
    .clk_i(clk), .rst_ni(rst_n), .idle_i(idle), .wake_i(wake), .greedy_i(greedy),
    .clear_i(clr), .mode_o(mode_s), .ready_o(ready_s), .energy_o(energy_s)
  );

  int vecs = 0, errs = 0;
  bit done = 0;

  // reference model state
  int m_mode = 0;      // 0 run 1 standby 2 sleep 3 transition
  int m_after = 0;     // mode reached when the transition ends
  int m_left = 0;
  bit m_down = 0;      // present transition is a shutdown
  bit m_pend = 0;
  int m_streak = 0;
  longint m_e = 0;

  function automatic int wgt(int md);
    if (md == 1) return 4;
    if (md == 2) return 1;
    return 16;
  endfunction

  task automatic begin_tr(int tgt, int len, bit down);
    m_mode = 3; m_after = tgt; m_left = len; m_down = down; m_streak = 0;
  endtask

  task automatic model_step(bit i, bit w, bit c, bit g);
    m_e = c ? 0 : m_e + wgt(m_mode);
    case (m_mode)
      3: begin
        if (m_down && w) m_pend = 1;
        m_left--;
        if (m_left == 0) m_mode = m_after;
      end
      0: begin
        m_streak = i ? m_streak + 1 : 0;
        if (g && i) begin_tr(2, L_SL, 1);
        else if (m_streak >= T_STBY) begin_tr(1, L_SS, 1);
      end
      1: begin
        if (w || m_pend) begin m_pend = 0; begin_tr(0, L_XS, 0); end
        else begin
          m_streak = i ? m_streak + 1 : 0;
          if ((g && i) || m_streak >= T_SLEEP) begin_tr(2, L_SL, 1);
        end
      end
      default: begin
        if (w || m_pend) begin m_pend = 0; begin_tr(0, L_XL, 0); end
      end
    endcase
  endtask

  task automatic compare(string tag, bit was_clr);
    longint em = (m_e > MAX_MAIN) ? MAX_MAIN : m_e;
    longint es = (m_e > MAX_SAT) ? MAX_SAT : m_e;
    bit bad = 0;
    string mtag = (m_mode == 3) ? "R3" : tag;
    vecs++;
    if (mode !== m_mode[1:0]) begin
      bad = 1; $display("FAIL %s mode actual=%0d expected=%0d", mtag, mode, m_mode);
    end
    if (ready !== (m_mode == 0)) begin
      bad = 1; $display("FAIL R13 ready actual=%0d expected=%0d", ready, m_mode == 0);
    end
    if (longint'(energy) != em) begin
      bad = 1; $display("FAIL %s energy actual=%0d expected=%0d", was_clr ? "R12" : "R10", energy, em);
    end
    if (longint'(energy_s) != es) begin
      bad = 1; $display("FAIL R11 saturating energy actual=%0d expected=%0d", energy_s, es);
    end
    if (bad) errs++;
  endtask

  task automatic tick(bit i, bit w, bit c, bit g, string tag);
    idle = i; wake = w; clr = c; greedy = g;
    model_step(i, w, c, g);
    @(posedge clk);
    @(negedge clk);
    compare(tag, c);
  endtask

  task automatic run_n(int n, bit i, bit w, bit c, bit g, string tag);
    for (int k = 0; k < n; k++) tick(i, w, c, g, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1", 0);               // reset values held under reset
    rst_n = 1'b1;
    tick(0, 0, 0, 0, "R1");

    // R2: broken idle run, then a full one
    run_n(5, 1, 0, 0, 0, "R2");
    tick(0, 0, 0, 0, "R2");
    run_n(7, 1, 0, 0, 0, "R2");
    tick(1, 0, 0, 0, "R2");
    run_n(L_SS + 2, 1, 0, 0, 0, "R2");

    // R5: wake from standby
    tick(1, 1, 0, 0, "R5");
    run_n(L_XS + 2, 0, 0, 0, 0, "R5");

    // R8: wake in run ignored
    run_n(4, 0, 1, 0, 0, "R8");

    // R12: clear in run
    run_n(2, 0, 0, 1, 0, "R12");
    run_n(20, 0, 0, 0, 0, "R11");

    // R4: standby, busy restart, then break-even threshold to sleep
    run_n(T_STBY + L_SS, 1, 0, 0, 0, "R4");
    run_n(100, 1, 0, 0, 0, "R4");
    tick(0, 0, 0, 0, "R4");
    run_n(T_SLEEP + L_SL + 4, 1, 0, 0, 0, "R4");

    // R6: wake from sleep, R8: wake during exit ignored
    tick(0, 1, 0, 0, "R6");
    run_n(10, 0, 0, 0, 0, "R6");
    run_n(3, 0, 1, 0, 0, "R8");
    run_n(L_XL, 0, 0, 0, 0, "R6");

    // R7: wake held during shutdown to standby
    run_n(T_STBY, 1, 0, 0, 0, "R7");
    tick(1, 0, 0, 0, "R7");
    tick(1, 1, 0, 0, "R7");
    run_n(L_SS + L_XS + 3, 1, 0, 0, 0, "R7");
    tick(0, 0, 0, 0, "R7");

    // R9: greedy from run; R7: wake in last shutdown cycle
    tick(1, 0, 0, 1, "R9");
    run_n(L_SL - 1, 0, 0, 0, 0, "R9");
    tick(0, 1, 0, 0, "R7");
    run_n(L_XL + 3, 0, 0, 1, 0, "R12");
    run_n(2, 0, 0, 0, 0, "R10");

    // R9: greedy from standby
    run_n(T_STBY + L_SS + 1, 1, 0, 0, 0, "R9");
    tick(1, 0, 0, 1, "R9");
    run_n(L_SL + 5, 0, 0, 0, 0, "R9");
    tick(0, 1, 0, 0, "R6");
    run_n(L_XL + 3, 0, 0, 0, 0, "R6");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule